// File: doc/BRIEF.md
# Falling-Edge Strobe Watchdog

This block watches a strobe line that software toggles from a general-purpose output. Only a high-to-low transition of that line counts as a service. If no such transition arrives before the selected period of millisecond ticks runs out, the block raises a one-cycle timeout request toward the system reset generator. The reset generator reports back through a reset-active input. While that input is high the timeout count is held at zero. Counting starts again when the input falls. If the strobe stays silent, a fresh request is issued once every period.

A 2-bit select picks the period. The nominal values are 150, 600 and 1200 ticks. A fourth code stands in for an unconnected select pin and behaves like the middle period. The strobe may be asynchronous. It passes through a two-flop synchroniser, then a falling-edge detector, and only then reaches the counter.

The control state machine has three states. HOLD keeps the count cleared while reset is active. COUNT accumulates ticks. FIRE drives the request for exactly one cycle. The transitions are:
- HOLD to COUNT when reset-active is sampled low.
- COUNT to HOLD when reset-active is sampled high.
- COUNT to FIRE on the tick that completes the period.
- FIRE to COUNT, with the count cleared, when no reset arrives.
- FIRE to HOLD when reset-active is sampled high.

Top module: `strobe_watchdog`

## Requirements
- R1: While rst_n is low and in the cycle after it rises, timeout_req is 0.
- R2: With period_sel = 2'b00, timeout_req rises on the clock edge that samples the 150th counted tick. A tick is counted when ms_tick is sampled high in the COUNT state, without a strobe clear on that edge.
- R3: With period_sel = 2'b01, the request follows the 600th counted tick.
- R4: With period_sel = 2'b10, the request follows the 1200th counted tick.
- R5: With period_sel = 2'b11 (the floating-pin code), the request follows the 600th counted tick.
- R6: A high-to-low transition of strobe_in restarts the count from zero. Ticks sampled up to and including the third clock edge that sees the strobe low are discarded.
- R7: A rising edge of strobe_in, or a strobe held at a steady level, leaves the count unchanged.
- R8: A strobe held low for only one clock period is still detected as a service.
- R9: timeout_req is high for exactly one cycle. While no falling edge arrives, a new request follows each further full period, counted from the edge after the previous request.
- R10: While sys_reset_active is sampled high, no request is made and the count is zero. After release, the first counted tick is the one sampled on the second edge that sees sys_reset_active low.
- R11: If period_sel changes to a period the running count has already reached, the request follows the next counted tick.
- R12: A request only begins on an edge at which ms_tick is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse once per millisecond |
| strobe_in | input | 1 | Software strobe; may be asynchronous |
| period_sel | input | 2 | Timeout period select: 00 short, 01 middle, 10 long, 11 middle |
| sys_reset_active | input | 1 | High while the system reset is being driven |
| timeout_req | output | 1 | One-cycle request to start a system reset |

## Verification
On every cycle, the checker confirms four behaviours: the request lasts a single cycle, it never appears while reset is active or right after a detected falling edge, the count is zero after reset-active, and the request only starts on a tick edge. The scenarios are what show the exact period for each select code, the latency of a falling strobe, the immunity to rising edges and steady levels, and the cadence of the repeated requests. They also show the effect of shrinking the period in mid-count.

// File: rtl/swd_pkg.sv
package swd_pkg;

    typedef enum logic [1:0] {
        WD_HOLD  = 2'd0,
        WD_COUNT = 2'd1,
        WD_FIRE  = 2'd2
    } wd_state_e;

    typedef enum logic [1:0] {
        SEL_SHORT = 2'b00,
        SEL_MID   = 2'b01,
        SEL_LONG  = 2'b10,
        SEL_FLOAT = 2'b11
    } wd_sel_e;

endpackage

// File: rtl/swd_strobe_edge.sv
module swd_strobe_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_async,
    output logic strobe_sync,
    output logic fall_pulse
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] chain;
    logic                   last_level;

    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[i] <= 1'b0;
                    else        chain[i] <= strobe_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[i] <= 1'b0;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) last_level <= 1'b0;
        else        last_level <= chain[TOP];
    end

    assign strobe_sync = chain[TOP];
    assign fall_pulse  = last_level & ~chain[TOP];

endmodule

// File: rtl/swd_period_decode.sv
module swd_period_decode
    import swd_pkg::*;
#(
    parameter int SHORT_TICKS = 150,
    parameter int MID_TICKS   = 600,
    parameter int LONG_TICKS  = 1200,
    parameter int CW          = 11
) (
    input  logic [1:0]    sel,
    output logic [CW-1:0] limit
);
    always_comb begin
        unique case (wd_sel_e'(sel))
            SEL_SHORT: limit = CW'(SHORT_TICKS);
            SEL_MID:   limit = CW'(MID_TICKS);
            SEL_LONG:  limit = CW'(LONG_TICKS);
            SEL_FLOAT: limit = CW'(MID_TICKS);
        endcase
    end

endmodule

// File: rtl/swd_tick_counter.sv
module swd_tick_counter #(
    parameter int CW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          clear,
    input  logic          enable,
    input  logic [CW-1:0] limit,
    output logic [CW-1:0] count,
    output logic          expire
);
    logic [CW-1:0] last_val;

    assign last_val = limit - CW'(1);
    assign expire   = enable & tick & ~clear & (count >= last_val);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            count <= '0;
        end else if (enable && tick && (count < limit)) begin
            count <= count + CW'(1);
        end
    end

endmodule

// File: rtl/strobe_watchdog.sv
module strobe_watchdog
    import swd_pkg::*;
#(
    parameter int SHORT_TICKS = 150,
    parameter int MID_TICKS   = 600,
    parameter int LONG_TICKS  = 1200,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ms_tick,
    input  logic       strobe_in,
    input  logic [1:0] period_sel,
    input  logic       sys_reset_active,
    output logic       timeout_req
);
    localparam int MAX_A = (SHORT_TICKS > MID_TICKS) ? SHORT_TICKS : MID_TICKS;
    localparam int MAX_T = (MAX_A > LONG_TICKS) ? MAX_A : LONG_TICKS;
    localparam int CNT_W = $clog2(MAX_T + 1);

    wd_state_e     state_q, state_d;
    logic          strobe_s;
    logic          fall_evt;
    logic [CNT_W-1:0] period_lim;
    logic [CNT_W-1:0] tick_cnt;
    logic          cnt_clear;
    logic          cnt_en;
    logic          period_done;

    swd_strobe_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk          (clk),
        .rst_n        (rst_n),
        .strobe_async (strobe_in),
        .strobe_sync  (strobe_s),
        .fall_pulse   (fall_evt)
    );

    swd_period_decode #(
        .SHORT_TICKS (SHORT_TICKS),
        .MID_TICKS   (MID_TICKS),
        .LONG_TICKS  (LONG_TICKS),
        .CW          (CNT_W)
    ) u_dec (
        .sel   (period_sel),
        .limit (period_lim)
    );

    assign cnt_en    = (state_q == WD_COUNT);
    assign cnt_clear = sys_reset_active | ~cnt_en | fall_evt;

    swd_tick_counter #(.CW(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (ms_tick),
        .clear  (cnt_clear),
        .enable (cnt_en),
        .limit  (period_lim),
        .count  (tick_cnt),
        .expire (period_done)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_HOLD:  if (!sys_reset_active) state_d = WD_COUNT;
            WD_COUNT: begin
                if (sys_reset_active) state_d = WD_HOLD;
                else if (period_done) state_d = WD_FIRE;
            end
            WD_FIRE:  state_d = sys_reset_active ? WD_HOLD : WD_COUNT;
            default:  state_d = WD_HOLD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WD_HOLD;
        else        state_q <= state_d;
    end

    always_comb begin
        timeout_req = (state_q == WD_FIRE);
    end

    logic unused_sync;
    assign unused_sync = strobe_s;

endmodule

// File: rtl/strobe_watchdog_chk.sv
module strobe_watchdog_chk #(
    parameter int CW = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ms_tick,
    input logic          sys_reset_active,
    input logic          timeout_req,
    input logic          fall,
    input logic [CW-1:0] cnt
);
    // R9
    single_cycle_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_req |=> !timeout_req);

    // R10
    no_req_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset_active |=> !timeout_req);

    // R10
    count_cleared_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset_active |=> (cnt == '0));

    // R6
    fall_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !timeout_req);

    // R12
    req_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_req) |-> $past(ms_tick));

endmodule

bind strobe_watchdog strobe_watchdog_chk #(.CW(CNT_W)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .ms_tick          (ms_tick),
    .sys_reset_active (sys_reset_active),
    .timeout_req      (timeout_req),
    .fall             (fall_evt),
    .cnt              (tick_cnt)
);

// File: tb/tb_strobe_watchdog.sv
`timescale 1ns/1ps
module tb_strobe_watchdog;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ms_tick = 1'b0;
    logic       strobe_in = 1'b1;
    logic [1:0] period_sel = 2'b00;
    logic       sys_reset_active = 1'b1;
    logic       timeout_req;

    int checks = 0;
    int errors = 0;

    strobe_watchdog dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .ms_tick          (ms_tick),
        .strobe_in        (strobe_in),
        .period_sel       (period_sel),
        .sys_reset_active (sys_reset_active),
        .timeout_req      (timeout_req)
    );

    always #2 clk = ~clk;

    // tick high every other cycle; changes just after a rising edge
    always @(posedge clk) begin
        #1 ms_tick = ~ms_tick;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // counts ticks from the current negedge; expects the request on tick n_exp
    task automatic count_expect(input int n_exp, input string tag);
        int  n = 0;
        bit  seen = 1'b0;
        for (int g = 0; g < n_exp * 4 + 20 && !seen; g++) begin
            int pend = int'(ms_tick);
            @(negedge clk);
            n += pend;
            if (timeout_req) seen = 1'b1;
        end
        check(seen && n == n_exp, tag, seen ? n : -1, n_exp);
    endtask

    // counts k ticks and expects no request meanwhile
    task automatic count_quiet(input int k, input string tag);
        int n = 0;
        bit bad = 1'b0;
        while (n < k) begin
            int pend = int'(ms_tick);
            @(negedge clk);
            n += pend;
            if (timeout_req) bad = 1'b1;
        end
        check(!bad, tag, int'(bad), 0);
    endtask

    task automatic skip_edges(input int k);
        for (int i = 0; i < k; i++) @(negedge clk);
    endtask

    task automatic start_period(input logic [1:0] sel);
        @(negedge clk);
        sys_reset_active = 1'b1;
        period_sel = sel;
        strobe_in = 1'b1;
        skip_edges(4);
        sys_reset_active = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        skip_edges(3);
        check(timeout_req == 1'b0, "R1 during reset", int'(timeout_req), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(timeout_req == 1'b0, "R1 after reset", int'(timeout_req), 0);
    endtask

    task automatic t_select();
        start_period(2'b00); count_expect(150,  "R2 short period");
        start_period(2'b01); count_expect(600,  "R3 middle period");
        start_period(2'b10); count_expect(1200, "R4 long period");
        start_period(2'b11); count_expect(600,  "R5 floating code");
    endtask

    task automatic t_repeat();
        start_period(2'b00);
        count_expect(150, "R9 first request");
        for (int r = 0; r < 2; r++) begin
            @(negedge clk);
            check(timeout_req == 1'b0, "R9 single cycle", int'(timeout_req), 0);
            count_expect(150, "R9 repeated request");
        end
    endtask

    task automatic t_fall_and_levels();
        start_period(2'b00);
        count_quiet(100, "R6 quiet before strobe");
        strobe_in = 1'b0;
        skip_edges(3);
        count_expect(150, "R6 restart on falling edge");
        @(negedge clk);
        count_expect(150, "R7 steady low gives no service");
        @(negedge clk);
        count_quiet(50, "R7 quiet before rise");
        strobe_in = 1'b1;
        count_expect(100, "R7 rising edge ignored");
    endtask

    task automatic t_short_pulse();
        start_period(2'b00);
        count_quiet(60, "R8 quiet before pulse");
        strobe_in = 1'b0;
        @(negedge clk);
        strobe_in = 1'b1;
        skip_edges(2);
        count_expect(150, "R8 one-cycle low detected");
    endtask

    task automatic t_hold();
        @(negedge clk);
        period_sel = 2'b00;
        sys_reset_active = 1'b1;
        count_quiet(400, "R10 no request while held");
        sys_reset_active = 1'b0;
        @(negedge clk);
        count_quiet(100, "R10 quiet after release");
        sys_reset_active = 1'b1;
        skip_edges(10);
        sys_reset_active = 1'b0;
        @(negedge clk);
        count_expect(150, "R10 count restarts after release");
    endtask

    task automatic t_sel_change();
        start_period(2'b10);
        count_quiet(200, "R11 quiet on long period");
        period_sel = 2'b00;
        count_expect(1, "R11 shrink past count");
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_select();
        t_repeat();
        t_fall_and_levels();
        t_short_pulse();
        t_hold();
        t_sel_change();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule